// File: doc/BRIEF.md
# Recording Gain Controller with Noise Gate

This block steers the gain code of a recording-path amplifier from a stream of level measurements. Each time `level_stb` pulses, it compares the measured level with a target. It then moves the gain by at most one 0.75 dB step, at a pace set by programmable attack and decay codes. Levels and the target are both given as attenuation below full scale, in 0.75 dB units: 0 means 0 dBFS and a larger number means a quieter signal.

The block has two control behaviours. In level-tracking mode it pulls the gain down when the signal is too loud and pushes it up when the signal is too quiet. In limiter mode it only cuts the gain on loud signals; otherwise it lets the gain recover toward a programmed ceiling. A noise gate with hysteresis watches for quiet passages. While the gate is closed it either freezes the gain or raises a mute flag. A small write-only register port configures all of these settings.

Top module: `agc_gate_ctrl`

## Requirements
- R1: After reset, `gain` is 16 and `mute` is 0. The attack code resets to 2 and the decay code to 3. The control select resets to 00, the mode to level tracking, the gate threshold code to 0, gate enable and gate action to 0, and the ceiling to 40.
- R2: When the action is to lower the gain, one step is taken every 9·2^min(a,10) strobes, where a is the attack code. Codes 10 to 15 all give 9216 strobes. A strobe that switches the action counts as the first strobe of the new interval.
- R3: When the action is to raise the gain, one step is taken every 36·2^min(d,10) strobes, where d is the decay code. Codes 10 to 15 all give 36864 strobes.
- R4: In level-tracking mode (mode bit 0), the gain is lowered when the level is louder than the target (attenuation smaller). It is raised up to 63 when the level is quieter. It is held when the level equals the target.
- R5: In limiter mode (mode bit 1), the gain is lowered when the level is louder than the target. Otherwise it rises toward the ceiling register and never rises above it.
- R6: The gain stays within 0 to 63 and never wraps. It changes by at most one step per cycle and only on a cycle with `level_stb` high.
- R7: While the control select is 00, the gain does not move. A write to the mode bit takes effect only if the select held before the write is 00; otherwise the mode bit is left as it was.
- R8: With threshold code c, the gate closes on a strobe whose attenuation exceeds 102−2c (that is, −76.5 dBFS + 1.5c dB). It opens again only on a strobe whose attenuation is below 98−2c (3 dB of hysteresis). Between these two values the gate keeps its state.
- R9: With the gate enabled and gate action 0, the gain is frozen on strobes that leave the gate closed. With the gate enabled and gate action 1, `mute` is 1 while the gate is closed. With the gate disabled, the gate affects neither output.
- R10: Register writes (`cfg_we` high) use this layout. Address 0 holds the attack code in bits 3:0 and the decay code in bits 7:4. Address 1 holds the mode in bit 0 and the control select in bits 2:1. Address 2 holds the threshold code in bits 4:0, the gate action in bit 5 and the gate enable in bit 6. Address 3 holds the ceiling in bits 5:0. A strobe in the same cycle as a write uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| level_stb | input | 1 | One pulse per new level sample |
| level_atten | input | 8 | Measured level, attenuation below full scale in 0.75 dB units |
| target_atten | input | 8 | Target level, same units |
| gain | output | 6 | Gain code, 0.75 dB per step |
| mute | output | 1 | Output mute request from the noise gate |

## Verification
A faulty step counter shows at `gain` as a step taken one or more strobes early or late. That can take up to 36864 strobes to appear at the longest codes, so the saturated codes are timed directly. A wrong gate state or a wrong mode bit is visible within one strobe: `mute` changes or fails to change, or the gain moves at a level equal to the target when it should hold. A wrong saturation or wrap appears on the first strobe that pushes the gain past 0 or 63.

// File: rtl/agc_gate_ctrl.sv
module agc_gate_ctrl #(
  parameter int GW       = 6,
  parameter int LW       = 8,
  parameter int CW       = 16,
  parameter int ATK_BASE = 9,
  parameter int DCY_BASE = 36,
  parameter int CODE_MAX = 10,
  parameter int GATE_BASE = 102,
  parameter int HYST     = 4,
  parameter int GAIN_RST = 16,
  parameter int CEIL_RST = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          level_stb,
  input  logic [LW-1:0] level_atten,
  input  logic [LW-1:0] target_atten,
  output logic [GW-1:0] gain,
  output logic          mute
);
  localparam logic [1:0] HOLD = 2'd0, DN = 2'd1, UP = 2'd2;

  logic [3:0]    atk, dcy;
  logic          mode;
  logic [1:0]    sel;
  logic [4:0]    thr;
  logic          ng_mute, ng_en;
  logic [GW-1:0] ceil_r;
  logic [GW-1:0] gain_q;
  logic          gate_q;
  logic [1:0]    act_q, act;
  logic [CW-1:0] cnt, per, atk_per, dcy_per;
  logic [LW-1:0] thr_close, thr_open;
  logic          gate_nx;
  logic [GW-1:0] top;

  assign atk_per   = CW'(ATK_BASE) << ((atk > 4'(CODE_MAX)) ? 4'(CODE_MAX) : atk);
  assign dcy_per   = CW'(DCY_BASE) << ((dcy > 4'(CODE_MAX)) ? 4'(CODE_MAX) : dcy);
  assign thr_close = LW'(GATE_BASE) - LW'({thr, 1'b0});
  assign thr_open  = thr_close - LW'(HYST);
  assign gate_nx   = (level_atten > thr_close) ? 1'b1 :
                     (level_atten < thr_open)  ? 1'b0 : gate_q;
  assign top       = mode ? ceil_r : {GW{1'b1}};

  always_comb begin
    if (sel == 2'b00 || (ng_en && !ng_mute && gate_nx))
      act = HOLD;
    else if (level_atten < target_atten)
      act = DN;
    else if (level_atten > target_atten || mode)
      act = UP;
    else
      act = HOLD;
  end

  assign per  = (act == DN) ? atk_per : dcy_per;
  assign gain = gain_q;
  assign mute = ng_en & ng_mute & gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      atk     <= 4'd2;
      dcy     <= 4'd3;
      mode    <= 1'b0;
      sel     <= 2'b00;
      thr     <= 5'd0;
      ng_mute <= 1'b0;
      ng_en   <= 1'b0;
      ceil_r  <= GW'(CEIL_RST);
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: begin atk <= cfg_wdata[3:0]; dcy <= cfg_wdata[7:4]; end
        2'd1: begin
          sel <= cfg_wdata[2:1];
          if (sel == 2'b00) mode <= cfg_wdata[0];
        end
        2'd2: begin thr <= cfg_wdata[4:0]; ng_mute <= cfg_wdata[5]; ng_en <= cfg_wdata[6]; end
        default: ceil_r <= cfg_wdata[GW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GW'(GAIN_RST);
      gate_q <= 1'b0;
      act_q  <= HOLD;
      cnt    <= '0;
    end else if (level_stb) begin
      gate_q <= gate_nx;
      act_q  <= act;
      if (act == HOLD)
        cnt <= '0;
      else if (act != act_q)
        cnt <= CW'(1);
      else if (cnt + CW'(1) >= per) begin
        cnt <= '0;
        if (act == DN && gain_q != '0) gain_q <= gain_q - GW'(1);
        if (act == UP && gain_q < top) gain_q <= gain_q + GW'(1);
      end else
        cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/agc_gate_ctrl_chk.sv
module agc_gate_ctrl_chk #(
  parameter int GW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          level_stb,
  input logic [GW-1:0] gain,
  input logic [1:0]    sel,
  input logic          mode,
  input logic [GW-1:0] ceil_r,
  input logic          ng_en,
  input logic          ng_mute,
  input logic          gate_q
);
  a_r6_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, gain} == {1'b0, $past(gain)}) ||
             ({1'b0, gain} == {1'b0, $past(gain)} + 1'b1) ||
             ({1'b0, gain} + 1'b1 == {1'b0, $past(gain)}));

  a_r6_no_strobe_still: assert property (@(posedge clk) disable iff (!rst_n)
    !level_stb |=> $stable(gain));

  a_r7_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00) |=> $stable(gain));

  a_r9_gate_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (ng_en && !ng_mute) |=> (!gate_q || $stable(gain)));

  a_r5_under_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    mode |=> !(gain > $past(gain) && gain > $past(ceil_r)));
endmodule

bind agc_gate_ctrl agc_gate_ctrl_chk #(.GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .level_stb(level_stb), .gain(gain),
  .sel(sel), .mode(mode), .ceil_r(ceil_r), .ng_en(ng_en),
  .ng_mute(ng_mute), .gate_q(gate_q)
);

// File: tb/agc_gate_ctrl_tb.sv
module agc_gate_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       level_stb = 1'b0;
  logic [7:0] level_atten = 8'd0;
  logic [7:0] target_atten = 8'd0;
  logic [5:0] gain;
  logic       mute;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  agc_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .level_stb(level_stb), .level_atten(level_atten),
    .target_atten(target_atten), .gain(gain), .mute(mute)
  );

  int m_atk, m_dcy, m_mode, m_sel, m_thr, m_ngm, m_nge, m_ceil;
  int m_gain, m_gate, m_act, m_cnt, m_mute;

  task automatic chk(string tag, int act_v, int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
    end
  endtask

  function automatic int lim(int c);
    return (c > 10) ? 10 : c;
  endfunction

  task automatic m_reset();
    m_atk = 2; m_dcy = 3; m_mode = 0; m_sel = 0; m_thr = 0;
    m_ngm = 0; m_nge = 0; m_ceil = 40;
    m_gain = 16; m_gate = 0; m_act = 0; m_cnt = 0; m_mute = 0;
  endtask

  task automatic m_clock(bit we, int a, int d, bit s, int l, int t);
    if (s) begin
      int cls, gnx, act, per, top;
      cls = 102 - 2 * m_thr;
      gnx = (l > cls) ? 1 : (l < cls - 4) ? 0 : m_gate;
      top = m_mode ? m_ceil : 63;
      if (m_sel == 0 || (m_nge == 1 && m_ngm == 0 && gnx == 1)) act = 0;
      else if (l < t) act = 1;
      else if (l > t || m_mode == 1) act = 2;
      else act = 0;
      per = (act == 1) ? (9 << lim(m_atk)) : (36 << lim(m_dcy));
      if (act == 0) m_cnt = 0;
      else if (act != m_act) m_cnt = 1;
      else if (m_cnt + 1 >= per) begin
        m_cnt = 0;
        if (act == 1 && m_gain > 0) m_gain--;
        if (act == 2 && m_gain < top) m_gain++;
      end else m_cnt++;
      m_gate = gnx;
      m_act = act;
    end
    if (we) begin
      case (a)
        0: begin m_atk = d & 15; m_dcy = (d >> 4) & 15; end
        1: begin if (m_sel == 0) m_mode = d & 1; m_sel = (d >> 1) & 3; end
        2: begin m_thr = d & 31; m_ngm = (d >> 5) & 1; m_nge = (d >> 6) & 1; end
        default: m_ceil = d & 63;
      endcase
    end
    m_mute = m_nge & m_ngm & m_gate;
  endtask

  task automatic cyc(bit we, int a, int d, bit s, int l, int t, string tag);
    cfg_we = we; cfg_addr = 2'(a); cfg_wdata = 8'(d);
    level_stb = s; level_atten = 8'(l); target_atten = 8'(t);
    @(posedge clk);
    m_clock(we, a, d, s, l, t);
    @(negedge clk);
    chk(tag, gain, m_gain);
    chk("R9 mute", mute, m_mute);
  endtask

  task automatic wr(int a, int d);
    cyc(1, a, d, 0, 0, 0, "R10 write");
  endtask

  task automatic measure(int l, int t, output int n);
    int g0;
    g0 = gain;
    n = 0;
    while (gain == g0 && n < 40000) begin
      cyc(0, 0, 0, 1, l, t, "R2 R3 timing");
      n++;
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gain reset", gain, 16);
    chk("R1 mute reset", mute, 0);

    // R7: select 00 holds the gain even with a loud input
    for (int i = 0; i < 50; i++) cyc(0, 0, 0, 1, 0, 30, "R7 off");
    chk("R7 held while off", gain, 16);

    // R7: mode accepted with select 00, then ignored with select 01
    wr(1, 8'b011);
    wr(1, 8'b010);
    for (int i = 0; i < 300; i++) cyc(0, 0, 0, 1, 20, 20, "R5 recover");
    chk("R7 mode write ignored (limiter recovers at target)", gain, 17);

    // back to tracking mode
    wr(1, 8'b000); wr(1, 8'b000); wr(1, 8'b010);
    for (int i = 0; i < 300; i++) cyc(0, 0, 0, 1, 20, 20, "R4 hold");
    chk("R4 hold at target", gain, 17);

    // R2 attack timing and saturation
    wr(0, 8'h30);
    cyc(0, 0, 0, 1, 20, 20, "R4 hold");
    measure(0, 20, n); chk("R2 code 0 strobes", n, 9);
    wr(0, 8'h3A); cyc(0, 0, 0, 1, 20, 20, "R4 hold");
    measure(0, 20, n); chk("R2 code 10 strobes", n, 9216);
    wr(0, 8'h3F); cyc(0, 0, 0, 1, 20, 20, "R4 hold");
    measure(0, 20, n); chk("R2 code 15 strobes", n, 9216);

    // R3 decay timing and saturation
    wr(0, 8'h02); cyc(0, 0, 0, 1, 20, 20, "R4 hold");
    measure(60, 20, n); chk("R3 code 0 strobes", n, 36);
    wr(0, 8'hB2); cyc(0, 0, 0, 1, 20, 20, "R4 hold");
    measure(60, 20, n); chk("R3 code 11 strobes", n, 36864);

    // R6 floor: fast attack, drive to zero and beyond
    wr(0, 8'h00);
    for (int i = 0; i < 800; i++) cyc(0, 0, 0, 1, 0, 20, "R6 floor");
    chk("R6 floor at 0", gain, 0);
    // R4 ceiling at 63 in tracking mode
    for (int i = 0; i < 3000; i++) cyc(0, 0, 0, 1, 60, 20, "R4 rise");
    chk("R4 ceiling 63", gain, 63);

    // R8/R9 gate hold: threshold code 10 -> close above 82, open below 78
    wr(2, 8'h4A);
    cyc(0, 0, 0, 1, 0, 20, "R2");
    for (int i = 0; i < 100; i++) cyc(0, 0, 0, 1, 90, 20, "R9 frozen");
    n = gain;
    for (int i = 0; i < 100; i++) cyc(0, 0, 0, 1, 80, 20, "R8 hysteresis");
    chk("R8 gate stays closed in hysteresis band", gain, n);
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1, 77, 200, "R8 reopen");
    chk("R8 gate reopened, gain moves", gain, n - 1);

    // R9 mute action
    wr(2, 8'h6A);
    cyc(0, 0, 0, 1, 90, 20, "R9");
    chk("R9 mute on closed gate", mute, 1);
    cyc(0, 0, 0, 1, 80, 20, "R8");
    chk("R8 mute kept in band", mute, 1);
    cyc(0, 0, 0, 1, 77, 20, "R8");
    chk("R8 mute released", mute, 0);
    wr(2, 8'h2A);
    cyc(0, 0, 0, 1, 90, 20, "R9");
    chk("R9 disabled gate no mute", mute, 0);

    // R5 limiter ceiling
    wr(1, 8'b000); wr(1, 8'b001); wr(1, 8'b011); wr(3, 8'd30);
    for (int i = 0; i < 4000; i++) cyc(0, 0, 0, 1, 0, 20, "R5 cut");
    for (int i = 0; i < 2000; i++) cyc(0, 0, 0, 1, 40, 20, "R5 recover");
    chk("R5 limiter stops at ceiling", gain, 30);

    // random mix against the model
    for (int i = 0; i < 20000; i++) begin
      int a, d, t;
      bit we;
      we = ($urandom % 20) == 0;
      a = $urandom % 4;
      d = $urandom % 256;
      if (a == 0) d = (($urandom % 3) << 4) | ($urandom % 3);
      t = 10 + (i / 1000) * 4;
      cyc(we, a, d, ($urandom % 10) < 7, $urandom % 120, t, "R4 R5 R6 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule